// File: doc/BRIEF.md
# Multichannel Serial Sample Framer

This block turns one parallel sample word per channel and per frame into serial lanes, one lane per channel. It runs on a bit-rate clock that is qualified by an enable, and sends one bit per enabled cycle. A frame holds one word, so it lasts `WORD_W` enabled cycles. Next to the lanes it drives a data clock that toggles on every bit, so a receiver can capture on both of its edges. It also drives a frame clock that is high during the first half of each word and low during the second half.

A sample is accepted at a frame boundary, which is the enabled cycle that carries the last bit of a word. That sample goes out as the word that starts `LATENCY` frames later. Before serialization the word can be recoded from offset binary into two's complement. It can be replaced by a test pattern on selected channels, or forced to zero on a powered-down lane. Configuration is held in four write-only registers. A write lands in the register at once but has no effect on the lanes until the next frame boundary, so a word is never split between two settings.

Top module: `adcf_framer`

## Requirements
- R1: While the internal reset is held, and on the first cycle after it is released, every lane is low, the frame clock is high, the data clock is low and the bit position is zero. The internal reset releases two clock edges after `rst_n` rises.
- R2: A frame is 14 enabled cycles long. The data clock toggles on every enabled cycle. The frame clock is high for bit positions 0 to 6 and low for positions 7 to 13. When `en` is low, no output and no internal state changes.
- R3: `smp_i` is sampled on the boundary edge, which is the enabled edge at bit position 13. Channel n occupies bits [14n+13:14n]. The sampled word is sent during the frame that starts at the 8th boundary after the one that sampled it. Before 8 boundaries have passed, the word sent is zero.
- R4: Register 0 bit 0 selects the bit order. When it is 0 (the reset value), the most significant bit goes first. When it is 1, the least significant bit goes first.
- R5: Register 0 bit 1 selects the coding. When it is 0, the sample is sent unchanged as offset binary. When it is 1, bit 13 of the sample is inverted, which gives two's complement. Patterns are never recoded.
- R6: Register 0 bits 7:4 select a pattern. Code 1 is a checkerboard that alternates 0x2AAA and 0x1555 from frame to frame, and the first frame after reset sends 0x2AAA. Code 2 is 0x3FFF, code 3 is 0x0000 and code 4 is 0x2000. Codes 0 and 7 to 15 send sample data.
- R7: Pattern code 5 sends a 9-bit linear feedback register, zero-extended to 14 bits. The register has taps at x^9 + x^5 + 1 and starts at 0x1FF after reset. It advances once per boundary in every mode, and each word carries the register value from before that boundary's step.
- R8: Pattern code 6 sends the word held in register 2, bits 13:0.
- R9: Register 3 bit n lets the pattern replace data on channel n. Its reset value is all ones. Register 1 bit n powers down channel n: that lane is held low for the whole word, whatever the pattern or data.
- R10: A register write, made while `cfg_we` is high, takes effect only at the next boundary edge, and writes do not depend on `en`. A write on the boundary edge itself first takes effect at the boundary after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Bit clock enable |
| smp_i | input | 112 | Parallel samples, 14 bits per channel, channel 0 in the low bits |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 power-down mask, 2 user word, 3 pattern mask |
| cfg_wdata | input | 16 | Register write data |
| sdo_o | output | 8 | Serial lanes, one per channel |
| dco_o | output | 1 | Data clock, one edge per bit |
| fco_o | output | 1 | Frame clock, high during the first half of each word |

## Verification
The main path is driven with fresh random samples on every channel in every frame, with the enable dropped at random times. Because each frame's samples differ, a latency off by one frame or a swapped channel shows up as a mismatch, and the gaps in the enable separate cycle counting from enable counting. The same random data is then sent LSB-first and with two's-complement coding, which exposes bit-order and top-bit errors that constant words would hide. Each pattern code is run over several frames, so the checkerboard phase and the pseudorandom sequence are checked, not only a first word. Pattern and power-down masks are set with mixed bits, and registers are written in the middle of frames, so per-channel selection and the boundary-only update are both tested.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

  // Pattern selector codes (control register bits 7:4)
  typedef enum logic [3:0] {
    PAT_NONE  = 4'd0,
    PAT_CHECK = 4'd1,
    PAT_ONES  = 4'd2,
    PAT_ZEROS = 4'd3,
    PAT_MID   = 4'd4,
    PAT_PRBS  = 4'd5,
    PAT_USER  = 4'd6
  } pat_mode_e;

  // Control register layout
  typedef struct packed {
    logic [7:0] rsvd;
    logic [3:0] mode;
    logic [1:0] spare;
    logic       twos;
    logic       lsb_first;
  } ctl_reg_t;

  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_PD    = 2'd1;
  localparam logic [1:0] ADDR_USER  = 2'd2;
  localparam logic [1:0] ADDR_PMASK = 2'd3;

  localparam int PRBS_W = 9;

  // One step of the x^9 + x^5 + 1 feedback register
  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[8] ^ s[4]};
  endfunction

endpackage

// File: rtl/adcf_timing.sv
module adcf_timing #(
  parameter int WORD_W = 14,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] bitpos,
  output logic          bnd,
  output logic          fco,
  output logic          dco
);

  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] HALF = CW'(WORD_W / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dco_q, dco_d;

  always_comb begin
    cnt_d = cnt_q;
    dco_d = dco_q;
    if (en) begin
      dco_d = ~dco_q;
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dco_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dco_q <= dco_d;
    end
  end

  assign bitpos = cnt_q;
  assign bnd    = en && (cnt_q == LAST);
  assign fco    = (cnt_q < HALF);
  assign dco    = dco_q;

  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r2_dco_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dco != $past(dco)));
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && $stable(dco)));
  a_r2_frame_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> fco);

endmodule

// File: rtl/adcf_cfg.sv
module adcf_cfg
  import adcf_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              bnd,
  output ctl_reg_t          ctl,
  output logic [NCH-1:0]    pd_mask,
  output logic [NCH-1:0]    pat_mask,
  output logic [WORD_W-1:0] user_word,
  output logic              lsb_act
);

  ctl_reg_t          ctl_q, ctl_d;
  logic [NCH-1:0]    pd_q, pd_d, pm_q, pm_d;
  logic [WORD_W-1:0] usr_q, usr_d;
  logic              lsb_q, lsb_d;

  always_comb begin
    ctl_d = ctl_q;
    pd_d  = pd_q;
    pm_d  = pm_q;
    usr_d = usr_q;
    lsb_d = lsb_q;
    if (bnd) lsb_d = ctl_q.lsb_first;
    if (cfg_we) begin
      unique case (cfg_addr)
        ADDR_CTL:   ctl_d = ctl_reg_t'(cfg_wdata);
        ADDR_PD:    pd_d  = cfg_wdata[NCH-1:0];
        ADDR_USER:  usr_d = cfg_wdata[WORD_W-1:0];
        ADDR_PMASK: pm_d  = cfg_wdata[NCH-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      pd_q  <= '0;
      pm_q  <= '1;
      usr_q <= '0;
      lsb_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      pd_q  <= pd_d;
      pm_q  <= pm_d;
      usr_q <= usr_d;
      lsb_q <= lsb_d;
    end
  end

  assign ctl       = ctl_q;
  assign pd_mask   = pd_q;
  assign pat_mask  = pm_q;
  assign user_word = usr_q;
  assign lsb_act   = lsb_q;

  a_r10_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(lsb_act));
  a_r10_order_taken: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (lsb_act == $past(ctl.lsb_first)));

endmodule

// File: rtl/adcf_patgen.sv
module adcf_patgen
  import adcf_pkg::*;
#(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd,
  input  logic [3:0]        mode,
  input  logic [WORD_W-1:0] user_word,
  output logic [WORD_W-1:0] pat_word,
  output logic              pat_on
);

  localparam logic [WORD_W-1:0] CHK_A = WORD_W'(14'h2AAA);
  localparam logic [WORD_W-1:0] CHK_B = WORD_W'(14'h1555);
  localparam logic [WORD_W-1:0] MID   = WORD_W'(1) << (WORD_W - 1);

  logic              chk_q, chk_d;
  logic [PRBS_W-1:0] prbs_q, prbs_d;

  always_comb begin
    chk_d  = chk_q;
    prbs_d = prbs_q;
    if (bnd) begin
      chk_d  = ~chk_q;
      prbs_d = prbs_step(prbs_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_q  <= 1'b0;
      prbs_q <= '1;
    end else begin
      chk_q  <= chk_d;
      prbs_q <= prbs_d;
    end
  end

  always_comb begin
    pat_on   = 1'b1;
    pat_word = '0;
    unique case (pat_mode_e'(mode))
      PAT_CHECK: pat_word = chk_q ? CHK_B : CHK_A;
      PAT_ONES:  pat_word = '1;
      PAT_ZEROS: pat_word = '0;
      PAT_MID:   pat_word = MID;
      PAT_PRBS:  pat_word = WORD_W'(prbs_q);
      PAT_USER:  pat_word = user_word;
      default:   pat_on   = 1'b0;
    endcase
  end

  a_r7_prbs_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_q != '0);
  a_r6_check_flips: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (chk_q != $past(chk_q)));
  a_r7_prbs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(prbs_q));

endmodule

// File: rtl/adcf_lane.sv
module adcf_lane #(
  parameter int WORD_W  = 14,
  parameter int LATENCY = 8,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd,
  input  logic [WORD_W-1:0] smp,
  input  logic              twos,
  input  logic              pd,
  input  logic              use_pat,
  input  logic [WORD_W-1:0] pat_word,
  input  logic              lsb_first,
  input  logic [CW-1:0]     bitpos,
  output logic              sdo
);

  localparam logic [WORD_W-1:0] TOP = WORD_W'(1) << (WORD_W - 1);

  logic [LATENCY-1:0][WORD_W-1:0] dly_q, dly_d;
  logic [WORD_W-1:0]              wrd_q, wrd_d, coded;
  logic                           pd_q, pd_d;
  logic [CW-1:0]                  idx;

  assign coded = dly_q[LATENCY-1] ^ (twos ? TOP : '0);

  always_comb begin
    dly_d = dly_q;
    wrd_d = wrd_q;
    pd_d  = pd_q;
    if (bnd) begin
      dly_d[0] = smp;
      for (int i = 1; i < LATENCY; i++) dly_d[i] = dly_q[i-1];
      pd_d = pd;
      if (pd)           wrd_d = '0;
      else if (use_pat) wrd_d = pat_word;
      else              wrd_d = coded;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      wrd_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      dly_q <= dly_d;
      wrd_q <= wrd_d;
      pd_q  <= pd_d;
    end
  end

  assign idx = lsb_first ? bitpos : CW'(WORD_W - 1) - bitpos;
  assign sdo = wrd_q[idx];

  a_r9_pd_low: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> (sdo == 1'b0));
  a_r9_pd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && !bnd) |=> $stable(sdo));
  a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(wrd_q));

endmodule

// File: rtl/adcf_framer.sv
module adcf_framer
  import adcf_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int WORD_W  = 14,
  parameter int LATENCY = 8,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [NCH*WORD_W-1:0] smp_i,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_addr,
  input  logic [15:0]           cfg_wdata,
  output logic [NCH-1:0]        sdo_o,
  output logic                  dco_o,
  output logic                  fco_o
);

  logic              rs1_q, rs2_q;
  logic [CW-1:0]     bitpos;
  logic              bnd;
  ctl_reg_t          ctl;
  logic [NCH-1:0]    pd_mask, pat_mask;
  logic [WORD_W-1:0] user_word, pat_word;
  logic              lsb_act, pat_on;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  adcf_timing #(.WORD_W(WORD_W)) u_timing (
    .clk    (clk),
    .rst_n  (rs2_q),
    .en     (en),
    .bitpos (bitpos),
    .bnd    (bnd),
    .fco    (fco_o),
    .dco    (dco_o)
  );

  adcf_cfg #(.NCH(NCH), .WORD_W(WORD_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rs2_q),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .bnd       (bnd),
    .ctl       (ctl),
    .pd_mask   (pd_mask),
    .pat_mask  (pat_mask),
    .user_word (user_word),
    .lsb_act   (lsb_act)
  );

  adcf_patgen #(.WORD_W(WORD_W)) u_pat (
    .clk       (clk),
    .rst_n     (rs2_q),
    .bnd       (bnd),
    .mode      (ctl.mode),
    .user_word (user_word),
    .pat_word  (pat_word),
    .pat_on    (pat_on)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    adcf_lane #(.WORD_W(WORD_W), .LATENCY(LATENCY)) u_lane (
      .clk       (clk),
      .rst_n     (rs2_q),
      .bnd       (bnd),
      .smp       (smp_i[ch*WORD_W +: WORD_W]),
      .twos      (ctl.twos),
      .pd        (pd_mask[ch]),
      .use_pat   (pat_on && pat_mask[ch]),
      .pat_word  (pat_word),
      .lsb_first (lsb_act),
      .bitpos    (bitpos),
      .sdo       (sdo_o[ch])
    );
  end

  a_r1_reset_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !rs2_q |=> (sdo_o == '0));
  a_r1_reset_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !rs2_q |=> (fco_o && !dco_o));

endmodule

// File: tb/adcf_framer_test.sv
`timescale 1ns/1ps
module adcf_framer_test;

  localparam int NCH = 8;
  localparam int W   = 14;
  localparam int LAT = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic [NCH*W-1:0] smp = '0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [15:0]      cfg_wdata = '0;
  logic [NCH-1:0]   sdo;
  logic             dco, fco;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    en_rand  = 1'b0;
  bit    done     = 1'b0;

  always #10 clk = ~clk;

  adcf_framer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_i(smp),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sdo_o(sdo), .dco_o(dco), .fco_o(fco)
  );

  // ---------------- behavioural reference model ----------------
  int             m_cnt = 0;
  bit             m_dco = 0;
  bit             m_lsb = 0;
  bit             m_chk = 0;
  int             m_prbs = 'h1FF;
  int             m_ctl = 0, m_pd = 0, m_usr = 0, m_pm = 'hFF;
  int             m_word [NCH];
  bit             m_s1 = 0, m_s2 = 0;
  logic [NCH*W-1:0] hist [$];

  task automatic model_reset();
    m_cnt = 0; m_dco = 0; m_lsb = 0; m_chk = 0; m_prbs = 'h1FF;
    m_ctl = 0; m_pd = 0; m_usr = 0; m_pm = 'hFF;
    for (int c = 0; c < NCH; c++) m_word[c] = 0;
    hist.delete();
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit was_live;
    was_live = m_s2;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1; m_s1 = 1;
    end
    if (!rst_n || !was_live) begin
      model_reset();
    end else begin
      if (en) begin
        if (m_cnt == W - 1) begin
          int mode, pat;
          bit pat_on;
          hist.push_front(smp);
          if (hist.size() > LAT + 1) void'(hist.pop_back());
          mode = (m_ctl >> 4) & 15;
          pat_on = 1;
          case (mode)
            1: pat = m_chk ? 'h1555 : 'h2AAA;
            2: pat = 'h3FFF;
            3: pat = 0;
            4: pat = 'h2000;
            5: pat = m_prbs;
            6: pat = m_usr & 'h3FFF;
            default: begin pat = 0; pat_on = 0; end
          endcase
          for (int c = 0; c < NCH; c++) begin
            int d;
            d = (hist.size() > LAT) ? int'(hist[LAT][c*W +: W]) : 0;
            if (m_ctl & 2) d = d ^ 'h2000;
            if ((m_pd >> c) & 1)                 m_word[c] = 0;
            else if (pat_on && ((m_pm >> c) & 1)) m_word[c] = pat;
            else                                 m_word[c] = d;
          end
          m_lsb  = m_ctl & 1;
          m_chk  = !m_chk;
          m_prbs = ((m_prbs << 1) & 'h1FF) | (((m_prbs >> 8) ^ (m_prbs >> 4)) & 1);
          m_cnt  = 0;
        end else begin
          m_cnt++;
        end
        m_dco = !m_dco;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_ctl = cfg_wdata;
          2'd1: m_pd  = cfg_wdata & 'hFF;
          2'd2: m_usr = cfg_wdata;
          2'd3: m_pm  = cfg_wdata & 'hFF;
          default: ;
        endcase
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2", "fco", int'(fco), (m_cnt < W/2) ? 1 : 0);
      chk("R2", "dco", int'(dco), int'(m_dco));
      for (int c = 0; c < NCH; c++) begin
        int b;
        b = m_lsb ? m_cnt : (W - 1 - m_cnt);
        chk(cur_req, $sformatf("lane%0d", c), int'(sdo[c]), (m_word[c] >> b) & 1);
      end
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) smp[c*W +: W] <= W'($urandom);
    en <= en_rand ? ($urandom % 4 != 0) : 1'b1;
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frames(int n);
    repeat (n * W) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: explicit reset-state check
    chk("R1", "reset lanes", int'(sdo), 0);
    chk("R1", "reset fco", int'(fco), 1);
    chk("R1", "reset dco", int'(dco), 0);
    rst_n = 1'b1;
    cur_req = "R3";
    frames(2);
    en_rand = 1'b1;          // R2: enable gaps
    frames(20);
    en_rand = 1'b0;
    cur_req = "R4";  wr(0, 'h01); frames(12);
    cur_req = "R5";  wr(0, 'h02); frames(12);
    cur_req = "R6";  wr(0, 'h10); frames(5);
    wr(0, 'h21); frames(3);
    wr(0, 'h30); frames(3);
    wr(0, 'h40); frames(3);
    wr(0, 'h90); frames(3);
    cur_req = "R7";  wr(0, 'h50); en_rand = 1'b1; frames(30); en_rand = 1'b0;
    cur_req = "R8";  wr(2, 'h1234); wr(0, 'h60); frames(4);
    cur_req = "R9";  wr(3, 'h3C); frames(4);
    wr(1, 'hA5); frames(4);
    wr(0, 'h03); frames(4);
    cur_req = "R10";
    for (int k = 0; k < 6; k++) begin
      repeat (k * 3 + 1) @(negedge clk);
      wr(1, k * 37);
      wr(0, (k & 1) | ((k % 7) << 4));
    end
    frames(10);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    n_checks++;
    done = 1'b1;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule